// File: doc/BRIEF.md
# Return-Address Stack with Fast-Return Shadow Registers

This block is the call/return stack of a small processor core. On a call, the core drives the return address, which is the address of the instruction after the call. The block stores it in a 21-bit-wide, 31-slot array. On a return, the block pops the most recent address and gives it back one cycle later as the next program counter. The pointer always names the most recently filled slot. Slot 0 is only a sentinel that means "empty" and never holds an address.

Every call request also captures a shadow copy of the working register, the status register and the bank-select register. A return may ask for a fast restore. In that case the block raises a one-cycle restore strobe together with the popped address, and the register file reloads those three registers from the shadow outputs. Without a fast restore, the strobe stays low and the registers are left alone.

Requests are single-cycle pulses and are accepted in every cycle. There is no back-pressure. Errors are reported on sticky flags instead of stalling: calling into a full stack, returning from an empty stack, and asking for a call and a return in the same cycle.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, `depth_o` is 0, and `full_o`, `ovf_o`, `unf_o`, `clash_o`, `ret_valid_o` and `restore_o` are all 0.
- R2: A call (`call_i`=1) with `depth_o` below 31 raises `depth_o` by one at the next edge and stores `call_addr_i` in the newly named slot.
- R3: A return (`ret_i`=1, `call_i`=0) with `depth_o` above 0 lowers `depth_o` by one. In the following cycle, `ret_valid_o` is 1 and `ret_pc_o` is the most recently stored address that has not yet been returned (last in, first out).
- R4: `full_o` is 1 exactly when `depth_o` is 31. A call while full leaves `depth_o` and the stored contents unchanged, and sets the sticky `ovf_o`.
- R5: A return while `depth_o` is 0 keeps `depth_o` at 0 and sets the sticky `unf_o`. In the following cycle, `ret_valid_o` is 1, `ret_pc_o` is 0 and `restore_o` is 0.
- R6: Every call request, accepted or refused, loads `wreg_i`, `stat_i` and `bank_i` into the shadow copies. The shadow copies appear on `wreg_o`, `stat_o` and `bank_o` from the next cycle on.
- R7: `restore_o` is 1 in the cycle after a successful return whose `fast_i` was 1. It is 0 after a return with `fast_i`=0.
- R8: A call and a return in the same cycle is an error. The call proceeds as in R2 and R4, the return is ignored (no `ret_valid_o` pulse and no pointer decrement), and the sticky `clash_o` is set.
- R9: Addresses across the full 21-bit range, including 0x000000 and 0x1FFFFF, are returned bit-exact.
- R10: `ret_valid_o` is a single-cycle pulse for each return request. It is 0 in a cycle that follows no return request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call request pulse |
| call_addr_i | input | 21 | Return address to store |
| ret_i | input | 1 | Return request pulse |
| fast_i | input | 1 | Restore shadow registers on this return |
| wreg_i | input | 8 | Live working register |
| stat_i | input | 5 | Live status register |
| bank_i | input | 4 | Live bank-select register |
| ret_pc_o | output | 21 | Popped address |
| ret_valid_o | output | 1 | `ret_pc_o` is valid this cycle |
| restore_o | output | 1 | Load shadow outputs into the register file |
| wreg_o | output | 8 | Shadow working register |
| stat_o | output | 5 | Shadow status register |
| bank_o | output | 4 | Shadow bank-select register |
| depth_o | output | 5 | Stack pointer: slot of the last stored entry |
| full_o | output | 1 | All 31 slots occupied |
| ovf_o | output | 1 | Sticky: call refused while full |
| unf_o | output | 1 | Sticky: return from empty stack |
| clash_o | output | 1 | Sticky: call and return in one cycle |

## Verification
A call and a return can fall in the same cycle. The bench provokes this by raising both requests together after one prior call. It then judges that no return pulse followed, that the depth grew by one, that the clash flag is set, and that the next ordinary return yields the address from the clashing call. A return can also coincide with a fast-restore request on an empty stack. There the bench checks that the underflow path wins and that the restore strobe stays low.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    OP_IDLE, OP_PUSH, OP_PUSH_FULL, OP_POP, OP_POP_EMPTY, OP_CLASH
  } ras_op_e;

  function automatic ras_op_e classify(input logic push, input logic pop,
                                       input logic at_top, input logic at_bottom);
    if (push && pop)  return OP_CLASH;
    if (push)         return at_top ? OP_PUSH_FULL : OP_PUSH;
    if (pop)          return at_bottom ? OP_POP_EMPTY : OP_POP;
    return OP_IDLE;
  endfunction
endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl #(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output ras_pkg::ras_op_e op,
  output logic [PTR_W-1:0] ptr,
  output logic [PTR_W-1:0] wr_slot,
  output logic             wr_en,
  output logic             full,
  output logic             ovf,
  output logic             unf,
  output logic             clash
);
  localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

  logic at_top, at_bottom;
  assign at_top    = (ptr == TOP);
  assign at_bottom = (ptr == '0);
  assign op        = ras_pkg::classify(push, pop, at_top, at_bottom);
  assign wr_en     = (op == ras_pkg::OP_PUSH) || (op == ras_pkg::OP_CLASH && !at_top);
  assign wr_slot   = ptr + 1'b1;
  assign full      = at_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr   <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
      clash <= 1'b0;
    end else begin
      if (wr_en)                    ptr <= wr_slot;
      else if (op == ras_pkg::OP_POP) ptr <= ptr - 1'b1;
      if (op == ras_pkg::OP_PUSH_FULL || (op == ras_pkg::OP_CLASH && at_top)) ovf <= 1'b1;
      if (op == ras_pkg::OP_POP_EMPTY) unf   <= 1'b1;
      if (op == ras_pkg::OP_CLASH)     clash <= 1'b1;
    end
  end
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_slot,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_slot,
  output logic [ADDR_W-1:0] rd_data
);
  localparam int SLOTS = (1 << PTR_W) - 1;

  logic [ADDR_W-1:0] slot_q [1:SLOTS];

  for (genvar g = 1; g <= SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && wr_slot == PTR_W'(g))
        slot_q[g] <= wr_data;
    end
  end

  // Slot 0 is the empty sentinel and reads as zero.
  always_comb begin
    rd_data = '0;
    for (int i = 1; i <= SLOTS; i++)
      if (rd_slot == PTR_W'(i)) rd_data = slot_q[i];
  end
endmodule

// File: rtl/ras_shadow.sv
module ras_shadow #(
  parameter int W_W   = 8,
  parameter int ST_W  = 5,
  parameter int BSR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [W_W-1:0]   w_in,
  input  logic [ST_W-1:0]  st_in,
  input  logic [BSR_W-1:0] bsr_in,
  output logic [W_W-1:0]   w_sh,
  output logic [ST_W-1:0]  st_sh,
  output logic [BSR_W-1:0] bsr_sh
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_sh   <= '0;
      st_sh  <= '0;
      bsr_sh <= '0;
    end else if (cap) begin
      w_sh   <= w_in;
      st_sh  <= st_in;
      bsr_sh <= bsr_in;
    end
  end
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5,
  parameter int W_W    = 8,
  parameter int ST_W   = 5,
  parameter int BSR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_i,
  input  logic [ADDR_W-1:0] call_addr_i,
  input  logic              ret_i,
  input  logic              fast_i,
  input  logic [W_W-1:0]    wreg_i,
  input  logic [ST_W-1:0]   stat_i,
  input  logic [BSR_W-1:0]  bank_i,
  output logic [ADDR_W-1:0] ret_pc_o,
  output logic              ret_valid_o,
  output logic              restore_o,
  output logic [W_W-1:0]    wreg_o,
  output logic [ST_W-1:0]   stat_o,
  output logic [BSR_W-1:0]  bank_o,
  output logic [PTR_W-1:0]  depth_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              unf_o,
  output logic              clash_o
);
  ras_pkg::ras_op_e  op;
  logic [PTR_W-1:0]  wr_slot;
  logic              wr_en;
  logic [ADDR_W-1:0] rd_data;

  ras_ptr_ctrl #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .push(call_i), .pop(ret_i),
    .op(op), .ptr(depth_o), .wr_slot(wr_slot), .wr_en(wr_en),
    .full(full_o), .ovf(ovf_o), .unf(unf_o), .clash(clash_o)
  );

  ras_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(wr_slot),
    .wr_data(call_addr_i), .rd_slot(depth_o), .rd_data(rd_data)
  );

  ras_shadow #(.W_W(W_W), .ST_W(ST_W), .BSR_W(BSR_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .cap(call_i),
    .w_in(wreg_i), .st_in(stat_i), .bsr_in(bank_i),
    .w_sh(wreg_o), .st_sh(stat_o), .bsr_sh(bank_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_pc_o    <= '0;
      ret_valid_o <= 1'b0;
      restore_o   <= 1'b0;
    end else begin
      ret_valid_o <= (op == ras_pkg::OP_POP) || (op == ras_pkg::OP_POP_EMPTY);
      ret_pc_o    <= (op == ras_pkg::OP_POP) ? rd_data : '0;
      restore_o   <= (op == ras_pkg::OP_POP) && fast_i;
    end
  end
endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
  parameter int ADDR_W = 21,
  parameter int PTR_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              call_i,
  input logic              ret_i,
  input logic [ADDR_W-1:0] ret_pc_o,
  input logic              ret_valid_o,
  input logic              restore_o,
  input logic [PTR_W-1:0]  depth_o,
  input logic              ovf_o,
  input logic              unf_o,
  input logic              clash_o
);
  localparam logic [PTR_W-1:0] TOP = {PTR_W{1'b1}};

  // R2
  push_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && depth_o != TOP |=> depth_o == $past(depth_o) + 1'b1);
  // R3
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !call_i && depth_o != '0 |=> depth_o == $past(depth_o) - 1'b1 && ret_valid_o);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && depth_o == TOP |=> ovf_o && depth_o == TOP);
  // R5
  underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i && !call_i && depth_o == '0 |=> unf_o && ret_pc_o == '0 && !restore_o);
  // R7
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> ret_valid_o);
  // R8
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    call_i && ret_i |=> clash_o && !ret_valid_o);
  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ret_i |=> !ret_valid_o);
endmodule

bind ret_addr_stack ras_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
  .ret_pc_o(ret_pc_o), .ret_valid_o(ret_valid_o), .restore_o(restore_o),
  .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o), .clash_o(clash_o)
);

// File: tb/tb_ret_addr_stack.sv
module tb_ret_addr_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, fast_i = 1'b0;
  logic [20:0] call_addr_i = '0;
  logic [7:0]  wreg_i = '0;
  logic [4:0]  stat_i = '0;
  logic [3:0]  bank_i = '0;
  logic [20:0] ret_pc_o;
  logic        ret_valid_o, restore_o, full_o, ovf_o, unf_o, clash_o;
  logic [7:0]  wreg_o;
  logic [4:0]  stat_o;
  logic [3:0]  bank_o;
  logic [4:0]  depth_o;

  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  ret_addr_stack dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_addr_i(call_addr_i),
    .ret_i(ret_i), .fast_i(fast_i), .wreg_i(wreg_i), .stat_i(stat_i),
    .bank_i(bank_i), .ret_pc_o(ret_pc_o), .ret_valid_o(ret_valid_o),
    .restore_o(restore_o), .wreg_o(wreg_o), .stat_o(stat_o), .bank_o(bank_o),
    .depth_o(depth_o), .full_o(full_o), .ovf_o(ovf_o), .unf_o(unf_o),
    .clash_o(clash_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; call_i = 0; ret_i = 0; fast_i = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one call for one cycle; returns at the next falling edge.
  task automatic do_call(input logic [20:0] a, input logic [7:0] w,
                         input logic [4:0] s, input logic [3:0] b);
    call_i = 1'b1; call_addr_i = a; wreg_i = w; stat_i = s; bank_i = b;
    @(negedge clk);
    call_i = 1'b0;
  endtask

  // Drive one return; outputs registered at the edge are sampled at the next falling edge.
  task automatic do_ret(input logic f);
    ret_i = 1'b1; fast_i = f;
    @(negedge clk);
    ret_i = 1'b0; fast_i = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 depth", depth_o, 0);
    check("R1 flags", {full_o, ovf_o, unf_o, clash_o, ret_valid_o, restore_o}, 0);
  endtask

  task automatic t_lifo();
    do_reset();
    do_call(21'h000123, 0, 0, 0);
    check("R2 depth after call", depth_o, 1);
    do_call(21'h0ABCDE, 0, 0, 0);
    do_call(21'h001000, 0, 0, 0);
    check("R2 depth after three calls", depth_o, 3);
    do_ret(1'b0);
    check("R3 valid", ret_valid_o, 1);
    check("R3 pc lifo 1", ret_pc_o, 32'h001000);
    check("R3 depth", depth_o, 2);
    @(negedge clk);
    check("R10 pulse ends", ret_valid_o, 0);
    do_ret(1'b0);
    check("R3 pc lifo 2", ret_pc_o, 32'h0ABCDE);
    do_ret(1'b0);
    check("R3 pc lifo 3", ret_pc_o, 32'h000123);
    check("R3 empty", depth_o, 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 31; i++) do_call(21'h100 + 21'(i), 0, 0, 0);
    check("R4 depth full", depth_o, 31);
    check("R4 full flag", full_o, 1);
    check("R4 no ovf yet", ovf_o, 0);
    do_call(21'h1ABCDE, 0, 0, 0);
    check("R4 ovf set", ovf_o, 1);
    check("R4 depth held", depth_o, 31);
    do_ret(1'b0);
    check("R4 top intact", ret_pc_o, 32'h11E);
    check("R4 not full", full_o, 0);
    check("R4 ovf sticky", ovf_o, 1);
  endtask

  task automatic t_underflow();
    do_reset();
    do_ret(1'b1);
    check("R5 valid", ret_valid_o, 1);
    check("R5 pc zero", ret_pc_o, 0);
    check("R5 no restore", restore_o, 0);
    check("R5 unf set", unf_o, 1);
    check("R5 depth", depth_o, 0);
  endtask

  task automatic t_shadow();
    do_reset();
    do_call(21'h000040, 8'h12, 5'h05, 4'h3);
    check("R6 shadow w", wreg_o, 8'h12);
    check("R6 shadow status", stat_o, 5'h05);
    check("R6 shadow bank", bank_o, 4'h3);
    do_call(21'h000080, 8'hA7, 5'h1A, 4'hC);
    check("R6 shadow recapture", {wreg_o, stat_o, bank_o}, {8'hA7, 5'h1A, 4'hC});
    do_ret(1'b1);
    check("R7 fast restore", restore_o, 1);
    check("R7 pc", ret_pc_o, 32'h000080);
    do_ret(1'b0);
    check("R7 normal return", restore_o, 0);
  endtask

  task automatic t_shadow_full();
    do_reset();
    for (int i = 0; i < 31; i++) do_call(21'(i), 0, 0, 0);
    do_call(21'h1F0000, 8'h5C, 5'h11, 4'h9);
    check("R6 capture on refused call", {wreg_o, stat_o, bank_o}, {8'h5C, 5'h11, 4'h9});
  endtask

  task automatic t_clash();
    do_reset();
    do_call(21'h000111, 0, 0, 0);
    call_i = 1'b1; call_addr_i = 21'h000222; ret_i = 1'b1;
    @(negedge clk);
    call_i = 1'b0; ret_i = 1'b0;
    check("R8 no return pulse", ret_valid_o, 0);
    check("R8 depth grew", depth_o, 2);
    check("R8 clash flag", clash_o, 1);
    do_ret(1'b0);
    check("R8 clashing call kept", ret_pc_o, 32'h000222);
  endtask

  task automatic t_range();
    do_reset();
    do_call(21'h1FFFFF, 0, 0, 0);
    do_call(21'h000000, 0, 0, 0);
    do_ret(1'b0);
    check("R9 zero address", ret_pc_o, 0);
    check("R9 valid", ret_valid_o, 1);
    do_ret(1'b0);
    check("R9 max address", ret_pc_o, 32'h1FFFFF);
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_overflow();
    t_underflow();
    t_shadow();
    t_shadow_full();
    t_clash();
    t_range();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule